// File: doc/BRIEF.md
# Prescaled PWM Generator with Off Encoding

This block is a single-channel pulse-width modulator. A programmable clock divider makes a tick, and a 16-bit counter steps on each tick from zero up to a programmed period limit and then returns to zero. The output is active while the counter is at or below a programmed duty limit. Software programs the divider, the period limit, the duty limit and a control word through a small write port. It reads the values currently in use back through a combinational read port.

Zero duty is held in the duty limit itself. Any duty limit greater than the period limit keeps the output inactive for the whole period. A duty limit of zero is therefore not silent: it still gives a one-tick pulse in every period. Normal operation keeps both limits at or below 0xFFFE, so a larger duty value is always available to mean "off". Period and duty writes go to shadow copies, and the counter takes them up only at its wrap. A one-cycle strobe marks the first cycle of every period.

Top module: `pwm_offenc_top`

## Requirements
- R1: After reset, all registers read zero, `pwm_out` is 0 and `wrap_stb` is 0.
- R2: Register map on `wr_addr`/`rd_addr`: 0 = divider, 1 = period limit, 2 = duty limit, 3 = control. In the control word, bit 0 is run and bit 1 is active-low. Control reads back as zeros above bit 1.
- R3: With divider value P and period limit C, one period lasts (P+1)*(C+1) clock cycles.
- R4: With duty limit D no greater than C, the output is active for (P+1)*(D+1) clock cycles of each period. D = 0 gives exactly one tick of P+1 cycles.
- R5: With D greater than C, the output stays inactive for the whole period while running. This is the zero-duty encoding, and it does not depend on the run bit.
- R6: With active-low set, the active level is 0 and the inactive level is 1. Otherwise active is 1.
- R7: While run is clear, the output sits at the inactive level, and the divider and counter are held at zero. The in-use limits follow the written limits.
- R8: While running, writes to the period or duty limit do not change the in-use values until the next wrap. Reads at addresses 1 and 2 return the in-use values.
- R9: `wrap_stb` is high for one cycle, in the first cycle of each period, when the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data (combinational) |
| pwm_out | output | 1 | Modulated output |
| wrap_stb | output | 1 | One-cycle pulse at the start of each period |

## Verification
The period and high time are measured between two strobes and tried with several settings:
- a mid-range duty, which separates the period formula from the high-time formula;
- duty zero, which separates the one-tick pulse from silence;
- duty equal to the period, which shows the full-on edge;
- duty above the period, which shows the off encoding;
- divider values above zero, which show that every tick is stretched;
- active-low settings, which show that the level inversion covers both the pulse and the idle level.

Directed tests cover the reset state and the idle level while stopped. They also cover a duty update written mid-period: it must stay invisible on read-back until the wrap and must then set the high time.

// File: rtl/pwm_offenc_pkg.sv
package pwm_offenc_pkg;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_DIV  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_DUTY = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             run;
        logic             act_low;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic             stb;
    } period_t;
endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div_val,
    output logic         tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q >= div_val);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: divider held at zero while stopped
    a_r7_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_offenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_wr,
    input  logic [CNT_W-1:0] duty_wr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_use,
    output logic [CNT_W-1:0] duty_use,
    output logic             wrap_stb
);
    period_t st_d, st_q;
    logic    wrap_d;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        wrap_d   = 1'b0;
        if (!run) begin
            st_d.cnt  = '0;
            st_d.per  = per_wr;
            st_d.duty = duty_wr;
        end else if (tick) begin
            if (st_q.cnt >= st_q.per) begin
                wrap_d    = 1'b1;
                st_d.cnt  = '0;
                st_d.per  = per_wr;
                st_d.duty = duty_wr;
                st_d.stb  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign per_use  = st_q.per;
    assign duty_use = st_q.duty;
    assign wrap_stb = st_q.stb;

    // R9: strobe only in the first cycle of a period
    a_r9_stb_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_stb |-> cnt == '0);
    // R8: in-use limits stay put between wraps while running
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap_d) |=> ($stable(per_use) && $stable(duty_use)));
    // R3: counter never passes the in-use period limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_use);
    // R7: counter held at zero while stopped
    a_r7_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_offenc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             act_low,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_use,
    input  logic [CNT_W-1:0] duty_use,
    output logic             pwm_out
);
    logic live_d;
    logic active_d;

    always_comb begin
        live_d   = (duty_use <= per_use);
        active_d = run && live_d && (cnt <= duty_use);
        pwm_out  = active_d ^ act_low;
    end

    // R5: off encoding keeps the output at the inactive level
    a_r5_off_code: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_use > per_use) |-> pwm_out == act_low);
    // R4: the first tick of a live period is active
    a_r4_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == '0 && duty_use <= per_use) |-> pwm_out != act_low);
endmodule

// File: rtl/pwm_offenc_top.sv
module pwm_offenc_top
    import pwm_offenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pwm_out,
    output logic              wrap_stb
);
    regs_t            rg_d, rg_q;
    logic             tick;
    logic [CNT_W-1:0] cnt, per_use, duty_use;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_DIV:  rg_d.div  = wr_data[DIV_W-1:0];
                ADR_PER:  rg_d.per  = wr_data;
                ADR_DUTY: rg_d.duty = wr_data;
                default: begin
                    rg_d.run     = wr_data[0];
                    rg_d.act_low = wr_data[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (rd_addr)
            ADR_DIV:  rd_data = CNT_W'(rg_q.div);
            ADR_PER:  rd_data = per_use;
            ADR_DUTY: rd_data = duty_use;
            default:  rd_data = {{(CNT_W-2){1'b0}}, rg_q.act_low, rg_q.run};
        endcase
    end

    pwm_tick_div #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(rg_q.run), .div_val(rg_q.div), .tick(tick)
    );

    pwm_period_ctr u_per (
        .clk(clk), .rst_n(rst_n), .run(rg_q.run), .tick(tick),
        .per_wr(rg_q.per), .duty_wr(rg_q.duty),
        .cnt(cnt), .per_use(per_use), .duty_use(duty_use), .wrap_stb(wrap_stb)
    );

    pwm_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .run(rg_q.run), .act_low(rg_q.act_low),
        .cnt(cnt), .per_use(per_use), .duty_use(duty_use), .pwm_out(pwm_out)
    );

    // R7: stopped output sits at the inactive level
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.run |-> pwm_out == rg_q.act_low);
    // R9: no strobe while stopped
    a_r9_no_stb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rg_q.run |=> !wrap_stb);
endmodule

// File: tb/pwm_offenc_top_tb_top.sv
`timescale 1ns/1ps
module pwm_offenc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        pwm_out;
    logic        wrap_stb;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pwm_offenc_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .wrap_stb(wrap_stb)
    );

    // {divider, period, duty, control}
    localparam logic [63:0] VEC [8] = '{
        {16'd0, 16'd9,  16'd4,      16'd1},
        {16'd0, 16'd9,  16'd0,      16'd1},
        {16'd1, 16'd7,  16'd3,      16'd1},
        {16'd2, 16'd5,  16'd5,      16'd1},
        {16'd0, 16'd9,  16'd10,     16'd1},
        {16'd3, 16'd4,  16'd1,      16'd3},
        {16'd0, 16'd3,  16'hFFFF,   16'd3},
        {16'd1, 16'd0,  16'd0,      16'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // at a negedge: wait for a strobe, then count one full period
    task automatic measure(input bit low, output int per, output int hi);
        int guard = 0;
        per = 0; hi = 0;
        while (!wrap_stb && guard < 100000) begin
            @(negedge clk); guard++;
        end
        do begin
            per++;
            if (pwm_out != low) hi++;
            @(negedge clk);
        end while (!wrap_stb && per < 100000);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int v, per, hi, e_per, e_hi;
        logic [15:0] p, c, d, ctl;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 wrap_stb", int'(wrap_stb), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 regs", v, 0);
        end
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            {p, c, d, ctl} = VEC[i];
            wr(2'd0, p); wr(2'd1, c); wr(2'd2, d);
            wr(2'd3, ctl);
            // R2: control read-back
            rd(2'd3, v);
            check("R2 ctrl", v, int'(ctl));
            measure(ctl[1], per, hi);
            e_per = (int'(p) + 1) * (int'(c) + 1);
            e_hi  = (d > c) ? 0 : (int'(p) + 1) * (int'(d) + 1);
            check("R3 period", per, e_per);
            check(d > c ? "R5 off" : (ctl[1] ? "R6 act-low high time" : "R4 high time"), hi, e_hi);
            // R2/R8: in-use limits read back
            @(negedge clk);
            rd(2'd1, v); check("R8 per rd", v, int'(c));
            rd(2'd2, v); check("R8 duty rd", v, int'(d));
            wr(2'd3, {14'd0, ctl[1], 1'b0});
            repeat (2) @(negedge clk);
            // R7: idle level after stop
            check("R7 idle level", int'(pwm_out), int'(ctl[1]));
            check("R9 no stb idle", int'(wrap_stb), 0);
        end

        // R7: idle with active-low, while counter would otherwise run
        wr(2'd3, 16'd2);
        repeat (5) @(negedge clk);
        check("R7 idle act-low", int'(pwm_out), 1);

        // R8: mid-period duty update
        wr(2'd0, 16'd0); wr(2'd1, 16'd9); wr(2'd2, 16'd4);
        wr(2'd3, 16'd1);
        while (!wrap_stb) @(negedge clk);
        // R9: strobe lasts one cycle
        @(negedge clk);
        check("R9 stb width", int'(wrap_stb), 0);
        wr(2'd2, 16'd7);
        rd(2'd2, v);
        check("R8 held before wrap", v, 4);
        while (!wrap_stb) @(negedge clk);
        rd(2'd2, v);
        check("R8 loaded at wrap", v, 7);
        measure(1'b0, per, hi);
        check("R4 new duty", hi, 8);
        check("R3 period kept", per, 10);

        // R5: off encoding while running, observed through a whole period
        wr(2'd2, 16'hFFFF);
        while (!wrap_stb) @(negedge clk);
        measure(1'b0, per, hi);
        check("R5 off running", hi, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule